// File: doc/BRIEF.md
# OFDM Transmit Frame Sequencer

This block assembles the complete baseband sample stream of one 20 MHz OFDM packet. A one-cycle start pulse, together with a count N of data symbols, launches a packet. The sequencer first plays the short training section, which is a 16-sample pattern repeated ten times. It then plays the long training section: a 32-sample guard copied from the back half of a 64-sample pattern, followed by two complete copies of that pattern. After the preamble it plays 1+N OFDM symbols. The first of these is the header symbol and the rest are data symbols.

Each symbol enters as a block of 64 time-domain samples on a valid/ready stream, with one sample per handshake. The block is held in one of two alternating buffers. When it is played out, its final 16 samples go first as the cyclic prefix, and then all 64 samples follow in order. The output is a gap-free stream of signed I/Q samples with start-of-packet and end-of-packet markers. If a block has not fully arrived by the time its symbol is due, the packet is cut short and an underrun pulse is raised.

Top module: `ofdm_tx_framer`

## Requirements
- R1: When idle, a start pulse launches a packet and latches n_data_sym as N. A start pulse that arrives while a packet is in progress has no effect on that packet's length or content.
- R2: Output samples 0..159 are the short training section. Sample k equals short pattern entry m = k mod 16, where the entry has I = 1000*(m+1) and Q = -1000*(m+1) as signed 16-bit values.
- R3: Output samples 160..319 are the long training section. Its first 32 samples are long pattern entries 32..63, followed by entries 0..63 twice. Long pattern entry m has I = 300*m - 9000 and Q = 7000 - 200*m.
- R4: After the preamble, each symbol occupies 80 samples. These are samples 48..63 of its input block (the cyclic prefix), followed by samples 0..63 of the same block.
- R5: Input blocks are played in arrival order, with the first block being the header symbol. A complete packet is exactly 320 + 80*(1+N) valid samples.
- R6: out_valid stays high on every cycle from the first preamble sample to the last sample of the packet.
- R7: out_sop is high only on the first preamble sample. out_eop is high only on the last sample of the final symbol.
- R8: in_ready is low while idle. During a packet, the block accepts exactly (1+N)*64 input samples and holds at most two whole blocks ahead of playback.
- R9: If a symbol's block is not complete when its first prefix sample is due, underrun pulses for one cycle with out_valid low. The packet then ends without out_eop, and the block returns to idle, where a later start pulse works normally.
- R10: After reset, out_valid, out_sop, out_eop, underrun and in_ready are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Packet launch pulse |
| n_data_sym | input | SYM_W | Number of data symbols after the header |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Input sample accepted when high together with in_valid |
| in_i | input | 16 | Input sample, in-phase, signed |
| in_q | input | 16 | Input sample, quadrature, signed |
| out_valid | output | 1 | Output sample valid |
| out_i | output | 16 | Output sample, in-phase, signed |
| out_q | output | 16 | Output sample, quadrature, signed |
| out_sop | output | 1 | First sample of packet |
| out_eop | output | 1 | Last sample of packet |
| underrun | output | 1 | Packet aborted for lack of a symbol block |

## Verification
Packets with N swept from 0 to 4 and one long packet with N = 40 are driven with a ramp-coded input. Because every input sample carries its own global index, each played sample can be traced to its source, so a wrong cyclic-prefix offset, a swapped bank or a reordered block shows up as a mismatch. Under-fed runs are used as well: one with no header block and one that stops after the header. These separate an abort at the header from an abort at a data symbol, and a recovery packet afterwards confirms the return to idle. A start pulse injected mid-packet with a different count shows whether the count latch is protected while the block is busy.

// File: rtl/ofdm_tx_pkg.sv
package ofdm_tx_pkg;

    localparam int SAMP_W    = 16;
    localparam int STS_LEN   = 16;
    localparam int STS_REP   = 10;
    localparam int LTS_LEN   = 64;
    localparam int LTS_GI    = 32;
    localparam int LTS_REP   = 2;
    localparam int BLK_LEN   = 64;
    localparam int CP_LEN    = 16;
    localparam int NUM_BANKS = 2;

    localparam int STS_TOTAL = STS_LEN * STS_REP;
    localparam int LTS_TOTAL = LTS_GI + LTS_LEN * LTS_REP;
    localparam int SYM_TOTAL = BLK_LEN + CP_LEN;
    localparam int STS_AW    = $clog2(STS_LEN);
    localparam int LTS_AW    = $clog2(LTS_LEN);
    localparam int BLK_AW    = $clog2(BLK_LEN);
    localparam int BANK_AW   = $clog2(NUM_BANKS);
    localparam int CNT_W     = $clog2(STS_TOTAL > LTS_TOTAL ? STS_TOTAL : LTS_TOTAL) + 1;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SHORT,
        PH_LONG,
        PH_SYM
    } phase_e;

    typedef struct packed {
        logic signed [SAMP_W-1:0] i;
        logic signed [SAMP_W-1:0] q;
    } iq_t;

    function automatic iq_t short_iq(input int k);
        iq_t r;
        r.i = SAMP_W'(1000 * (k + 1));
        r.q = SAMP_W'(-1000 * (k + 1));
        return r;
    endfunction

    function automatic iq_t long_iq(input int k);
        iq_t r;
        r.i = SAMP_W'(300 * k - 9000);
        r.q = SAMP_W'(7000 - 200 * k);
        return r;
    endfunction

endpackage

// File: rtl/ofdm_train_rom.sv
module ofdm_train_rom
    import ofdm_tx_pkg::*;
(
    input  logic [STS_AW-1:0] sts_idx,
    input  logic [LTS_AW-1:0] lts_idx,
    output iq_t               sts_smp,
    output iq_t               lts_smp
);

    iq_t sts_tbl [STS_LEN];
    iq_t lts_tbl [LTS_LEN];

    for (genvar k = 0; k < STS_LEN; k++) begin : g_sts
        assign sts_tbl[k] = short_iq(k);
    end

    for (genvar k = 0; k < LTS_LEN; k++) begin : g_lts
        assign lts_tbl[k] = long_iq(k);
    end

    assign sts_smp = sts_tbl[sts_idx];
    assign lts_smp = lts_tbl[lts_idx];

endmodule

// File: rtl/ofdm_sym_buf.sv
module ofdm_sym_buf #(
    parameter int DEPTH = 64,
    parameter int BANKS = 2,
    parameter int W     = 32
) (
    input  logic                            clk,
    input  logic                            wr_en,
    input  logic [$clog2(DEPTH*BANKS)-1:0]  wr_addr,
    input  logic [W-1:0]                    wr_data,
    input  logic [$clog2(DEPTH*BANKS)-1:0]  rd_addr,
    output logic [W-1:0]                    rd_data
);

    localparam int ENTRIES = DEPTH * BANKS;

    logic [W-1:0] mem_q [ENTRIES];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/ofdm_tx_framer.sv
module ofdm_tx_framer
    import ofdm_tx_pkg::*;
#(
    parameter int SYM_W = 10
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [SYM_W-1:0]         n_data_sym,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic signed [SAMP_W-1:0] in_i,
    input  logic signed [SAMP_W-1:0] in_q,
    output logic                     out_valid,
    output logic signed [SAMP_W-1:0] out_i,
    output logic signed [SAMP_W-1:0] out_q,
    output logic                     out_sop,
    output logic                     out_eop,
    output logic                     underrun
);

    localparam int IQ_W  = $bits(iq_t);
    localparam int BUF_AW = BANK_AW + BLK_AW;

    typedef struct packed {
        phase_e                 phase;
        logic [CNT_W-1:0]       cnt;
        logic [SYM_W:0]         sym_idx;
        logic [SYM_W:0]         total;
        logic [SYM_W:0]         blk_cnt;
        logic [BANK_AW-1:0]     wr_bank;
        logic [BLK_AW-1:0]      wr_idx;
        logic [NUM_BANKS-1:0]   full;
        logic [BANK_AW-1:0]     rd_bank;
        logic                   vld;
        logic                   sop;
        logic                   eop;
        logic                   urun;
        iq_t                    smp;
    } state_t;

    state_t st_d, st_q;

    iq_t              sts_smp, lts_smp, buf_smp;
    logic [IQ_W-1:0]  rd_word;
    logic             wr_en;

    // Index wrap-around: every offset below is taken modulo a power of two.
    ofdm_train_rom u_rom (
        .sts_idx (STS_AW'(st_q.cnt)),
        .lts_idx (LTS_AW'(st_q.cnt + CNT_W'(LTS_LEN - LTS_GI))),
        .sts_smp (sts_smp),
        .lts_smp (lts_smp)
    );

    ofdm_sym_buf #(
        .DEPTH (BLK_LEN),
        .BANKS (NUM_BANKS),
        .W     (IQ_W)
    ) u_buf (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (BUF_AW'({st_q.wr_bank, st_q.wr_idx})),
        .wr_data ({in_i, in_q}),
        .rd_addr (BUF_AW'({st_q.rd_bank, BLK_AW'(st_q.cnt + CNT_W'(BLK_LEN - CP_LEN))})),
        .rd_data (rd_word)
    );

    assign buf_smp  = iq_t'(rd_word);
    assign in_ready = (st_q.phase != PH_IDLE) && !st_q.full[st_q.wr_bank]
                      && (st_q.blk_cnt != st_q.total);
    assign wr_en    = in_valid && in_ready;

    always_comb begin
        st_d      = st_q;
        st_d.vld  = 1'b0;
        st_d.sop  = 1'b0;
        st_d.eop  = 1'b0;
        st_d.urun = 1'b0;
        st_d.smp  = '0;

        if (wr_en) begin
            st_d.wr_idx = st_q.wr_idx + 1'b1;
            if (st_q.wr_idx == BLK_AW'(BLK_LEN - 1)) begin
                st_d.full[st_q.wr_bank] = 1'b1;
                st_d.wr_bank            = st_q.wr_bank + 1'b1;
                st_d.blk_cnt            = st_q.blk_cnt + 1'b1;
            end
        end

        case (st_q.phase)
            PH_IDLE: begin
                if (start) begin
                    st_d.phase   = PH_SHORT;
                    st_d.cnt     = '0;
                    st_d.total   = {1'b0, n_data_sym} + 1'b1;
                    st_d.sym_idx = '0;
                    st_d.blk_cnt = '0;
                    st_d.wr_bank = '0;
                    st_d.wr_idx  = '0;
                    st_d.rd_bank = '0;
                    st_d.full    = '0;
                end
            end
            PH_SHORT: begin
                st_d.vld = 1'b1;
                st_d.smp = sts_smp;
                st_d.sop = (st_q.cnt == '0);
                st_d.cnt = st_q.cnt + 1'b1;
                if (st_q.cnt == CNT_W'(STS_TOTAL - 1)) begin
                    st_d.phase = PH_LONG;
                    st_d.cnt   = '0;
                end
            end
            PH_LONG: begin
                st_d.vld = 1'b1;
                st_d.smp = lts_smp;
                st_d.cnt = st_q.cnt + 1'b1;
                if (st_q.cnt == CNT_W'(LTS_TOTAL - 1)) begin
                    st_d.phase = PH_SYM;
                    st_d.cnt   = '0;
                end
            end
            PH_SYM: begin
                if (st_q.cnt == '0 && !st_q.full[st_q.rd_bank]) begin
                    st_d.urun  = 1'b1;
                    st_d.phase = PH_IDLE;
                    st_d.full  = '0;
                end else begin
                    st_d.vld = 1'b1;
                    st_d.smp = buf_smp;
                    st_d.cnt = st_q.cnt + 1'b1;
                    if (st_q.cnt == CNT_W'(SYM_TOTAL - 1)) begin
                        st_d.cnt                = '0;
                        st_d.full[st_q.rd_bank] = 1'b0;
                        st_d.rd_bank            = st_q.rd_bank + 1'b1;
                        if (st_q.sym_idx == st_q.total - 1'b1) begin
                            st_d.eop   = 1'b1;
                            st_d.phase = PH_IDLE;
                        end else begin
                            st_d.sym_idx = st_q.sym_idx + 1'b1;
                        end
                    end
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign out_i     = st_q.smp.i;
    assign out_q     = st_q.smp.q;
    assign out_sop   = st_q.sop;
    assign out_eop   = st_q.eop;
    assign underrun  = st_q.urun;

endmodule

// File: rtl/ofdm_tx_framer_chk.sv
module ofdm_tx_framer_chk (
    input logic clk,
    input logic rst_n,
    input logic in_ready,
    input logic out_valid,
    input logic out_sop,
    input logic out_eop,
    input logic underrun
);

    int unsigned len_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q <= 0;
        end else if (out_valid) begin
            len_q <= out_sop ? 1 : len_q + 1;
        end
    end

    AST_SOP_IS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        out_sop |-> out_valid); // R7

    AST_EOP_IS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        out_eop |-> out_valid); // R7

    AST_LEAD_SOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> out_sop); // R7

    AST_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_eop) |=> (out_valid || underrun)); // R6

    AST_URUN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |-> (!out_valid && !out_eop)); // R9

    AST_IDLE_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
        (out_eop || underrun) |=> !in_ready); // R8

    AST_PKT_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        out_eop |-> (len_q >= 399 && ((len_q - 319) % 80) == 0)); // R5

endmodule

bind ofdm_tx_framer ofdm_tx_framer_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_sop   (out_sop),
    .out_eop   (out_eop),
    .underrun  (underrun)
);

// File: tb/ofdm_tx_framer_tb_top.sv
`timescale 1ns/1ps
module ofdm_tx_framer_tb_top;

    localparam int SYM_W = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [SYM_W-1:0] n_data_sym = '0;
    logic in_valid, in_ready;
    logic signed [15:0] in_i, in_q;
    logic out_valid, out_sop, out_eop, underrun;
    logic signed [15:0] out_i, out_q;

    always #2.5 clk = ~clk;

    ofdm_tx_framer #(.SYM_W(SYM_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .n_data_sym(n_data_sym),
        .in_valid(in_valid), .in_ready(in_ready), .in_i(in_i), .in_q(in_q),
        .out_valid(out_valid), .out_i(out_i), .out_q(out_q),
        .out_sop(out_sop), .out_eop(out_eop), .underrun(underrun)
    );

    // Ramp-coded feeder: sample g of a packet carries its own index.
    int   feed_cnt = 0;
    int   feed_lim = 0;
    logic feed_rst = 1'b0;

    assign in_valid = (feed_cnt < feed_lim);
    assign in_i     = 16'(feed_cnt * 7 + 11);
    assign in_q     = 16'(-(feed_cnt * 5) - 3);

    always @(posedge clk) begin
        if (feed_rst) feed_cnt <= 0;
        else if (in_valid && in_ready) feed_cnt <= feed_cnt + 1;
    end

    int checks = 0;
    int failures = 0;

    logic [31:0] cap [8192];
    int cap_n, sops, sop_idx, eops, eop_idx, gaps, urun_n;
    bit timeout;

    function automatic logic [31:0] sexp(input int k);
        int m = k % 16;
        return {16'(1000 * (m + 1)), 16'(-1000 * (m + 1))};
    endfunction

    function automatic logic [31:0] lexp(input int m);
        return {16'(300 * m - 9000), 16'(7000 - 200 * m)};
    endfunction

    function automatic logic [31:0] dexp(input int g);
        return {16'(g * 7 + 11), 16'(-(g * 5) - 3)};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic run_pkt(input int n, input int lim_blocks, input int poke_at);
        int cyc = 0;
        bit started = 0;
        bit done = 0;
        @(negedge clk);
        feed_lim   = lim_blocks * 64;
        feed_rst   = 1'b1;
        start      = 1'b1;
        n_data_sym = SYM_W'(n);
        @(negedge clk);
        start    = 1'b0;
        feed_rst = 1'b0;
        cap_n = 0; sops = 0; sop_idx = -1; eops = 0; eop_idx = -1;
        gaps = 0; urun_n = 0; timeout = 0;
        while (!done) begin
            @(negedge clk);
            cyc++;
            if (cyc == poke_at) begin
                start      = 1'b1;
                n_data_sym = SYM_W'(n + 3);
            end else begin
                start = 1'b0;
            end
            if (out_valid) begin
                if (cap_n < 8192) cap[cap_n] = {out_i, out_q};
                if (out_sop) begin sops++; sop_idx = cap_n; end
                if (out_eop) begin eops++; eop_idx = cap_n; done = 1; end
                cap_n++;
                started = 1;
            end else if (started && !underrun) begin
                gaps++;
            end
            if (underrun) begin urun_n++; done = 1; end
            if (cyc > 20000) begin done = 1; timeout = 1; end
        end
        start = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic verify(input int n, input int lim_blocks);
        bit complete = (lim_blocks >= n + 1);
        int played = complete ? n + 1 : lim_blocks;
        int exp_len = 320 + 80 * played;
        int bad_s = 0, bad_l = 0, bad_cp = 0, bad_body = 0;
        chk(!timeout, "R5", "packet finished before timeout", int'(timeout), 0);
        chk(cap_n == exp_len, complete ? "R5" : "R9", "sample count", cap_n, exp_len);
        for (int k = 0; k < 160; k++)
            if (k < cap_n && cap[k] != sexp(k)) bad_s++;
        chk(bad_s == 0, "R2", "short section mismatches", bad_s, 0);
        for (int j = 0; j < 160; j++) begin
            int m = (j < 32) ? j + 32 : (j - 32) % 64;
            if (160 + j < cap_n && cap[160 + j] != lexp(m)) bad_l++;
        end
        chk(bad_l == 0, "R3", "long section mismatches", bad_l, 0);
        for (int s = 0; s < played; s++) begin
            int base = 320 + 80 * s;
            for (int j = 0; j < 16; j++)
                if (cap[base + j] != cap[base + 64 + j]) bad_cp++;
            for (int j = 0; j < 64; j++)
                if (cap[base + 16 + j] != dexp(s * 64 + j)) bad_body++;
        end
        chk(bad_cp == 0, "R4", "prefix vs symbol tail mismatches", bad_cp, 0);
        chk(bad_body == 0, "R5", "symbol body vs input order mismatches", bad_body, 0);
        chk(sops == 1 && sop_idx == 0, "R7", "sop count/position", sop_idx, 0);
        chk(eops == (complete ? 1 : 0), "R7", "eop count", eops, complete ? 1 : 0);
        if (complete)
            chk(eop_idx == exp_len - 1, "R7", "eop position", eop_idx, exp_len - 1);
        chk(gaps == 0, "R6", "valid gaps", gaps, 0);
        chk(urun_n == (complete ? 0 : 1), "R9", "underrun pulses", urun_n, complete ? 0 : 1);
        chk(feed_cnt == (complete ? (n + 1) * 64 : lim_blocks * 64), "R8",
            "accepted input samples", feed_cnt, complete ? (n + 1) * 64 : lim_blocks * 64);
        chk(!in_ready, "R8", "in_ready low when idle", int'(in_ready), 0);
    endtask

    initial begin
        #(5.0 * 150000);
        failures++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        chk(!out_valid && !out_sop && !out_eop && !underrun, "R10", "outputs after reset",
            int'({out_valid, out_sop, out_eop, underrun}), 0);
        chk(!in_ready, "R10", "in_ready after reset", int'(in_ready), 0);

        // R4 R5: sweep of short packets, header-only upward
        for (int n = 0; n < 5; n++) begin
            run_pkt(n, 1000, 0);
            verify(n, 1000);
        end
        run_pkt(40, 1000, 0);
        verify(40, 1000);

        // R1: start pulse with a different count mid-packet is ignored
        run_pkt(3, 1000, 100);
        verify(3, 1000);

        // R9: underrun at the header and at a data symbol, then recovery
        run_pkt(0, 0, 0);
        verify(0, 0);
        run_pkt(2, 1, 0);
        verify(2, 1);
        run_pkt(1, 1000, 0);
        verify(1, 1000);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule